// File: doc/BRIEF.md
# Host Bridge Configuration Cycle Generator

The bridge takes single CPU reads and writes aimed at a fixed 1 GiB window (addresses whose top two bits are `10`) and turns each one into a cycle on a simple request/acknowledge bus. A mode bit in a small control register picks the kind of cycle.

In memory mode, the low 30 request address bits pass straight through, and a 2-bit field of the control register supplies the top two bus address bits. In configuration mode, the request address carries a device number, a function number and a register offset. From these the bridge builds a configuration address whose IDSEL line is one-hot. Partial configuration writes are done as a read followed by a merged write.

Bus aborts and bus silence both count as master aborts. Either one sets a sticky status flag that software clears by writing one. A read that hits an abort returns all ones. Only memory and configuration commands are ever issued.

Top module: `cfg_bridge`

## Requirements
- R1: A request whose address bits [31:30] are not `10` completes without any bus cycle, with `req_err`=1 and `req_rdata`=0xFFFFFFFF.
- R2: In memory mode (control bit 1 clear), `bus_cfg`=0 and `bus_addr` = {control bits [3:2], request address [29:0]}. Write data passes unchanged. Read data returns unchanged. Exactly one bus cycle is made.
- R3: In configuration mode (control bit 1 set), `bus_cfg`=1 and `bus_addr` = (1 << (13+dev)) | (func << 8) | (offset & 0xFC). Here dev = address[15:11], func = address[10:8] and offset = address[7:0].
- R4: A configuration request with dev > 18, or with a formed address of 0x100000 or more, makes no bus cycle. It returns `req_err`=1 and 0xFFFFFFFF, and it leaves the abort flag clear.
- R5: `bus_abort` during a cycle sets the sticky abort flag, which reads as bit 26 of the status register (`reg_sel`=1). Writing a 1 to bit 26 clears it, a 0 there leaves it set, and a new abort wins over a clear in the same cycle.
- R6: Any aborted request returns `req_err`=1 and `req_rdata`=0xFFFFFFFF.
- R7: `req_size` selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. A configuration read returns (bus data >> 8·offset[1:0]) masked to that width. A sub-word configuration write first reads the word, then writes it with only the addressed bytes replaced by the shifted write data. If the read is aborted, no write follows.
- R8: Only one request is in flight. `req_ready` is a one-cycle pulse. `bus_req` and `bus_addr` hold steady until ack or abort. With an ack on the k-th bus cycle, `req_ready` rises k+1 cycles after acceptance.
- R9: A bus cycle that gets no response within 16 cycles ends as a master abort with the behaviour of R5 and R6.
- R10: The control register (`reg_sel`=0) holds the mode bit (bit 1) and the upper-address field (bits [3:2]). It reads back only those bits, and it and the abort flag reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | 32 | CPU address |
| req_wdata | input | 32 | CPU write data (sub-word data right-aligned) |
| req_ready | output | 1 | Completion pulse |
| req_err | output | 1 | Completion with reject or abort |
| req_rdata | output | 32 | Read result |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| bus_req | output | 1 | Bus cycle active |
| bus_cfg | output | 1 | 1 = configuration command, 0 = memory command |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus cycle completed |
| bus_abort | input | 1 | Bus cycle aborted |
| bus_rdata | input | 32 | Bus read data |

## Verification
Some properties are checked on every cycle:
- the completion pulse is a single cycle;
- the bus request holds its address while waiting;
- every configuration address carries exactly one IDSEL bit below bit 20;
- an abort always lands in the sticky flag, and the flag cannot drop without a write-one clear;
- an erroring completion always carries all ones;
- a timeout always ends the bus cycle.

Other behaviour only shows up in the bench's scenarios:
- the address arithmetic and upper-bit substitution;
- the read-modify-write merge for each byte lane;
- the shift and mask of sub-word reads;
- rejecting device numbers without touching the bus;
- the exact completion latency against a slow bus.

// File: rtl/cfg_bridge.sv
module cfg_bridge #(
  parameter int TMO           = 16,
  parameter int MAX_DEV       = 18,
  parameter int CFG_SPAN_BITS = 20,
  parameter int ABORT_BIT     = 26
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        req_err,
  output logic [31:0] req_rdata,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_req,
  output logic        bus_cfg,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_abort,
  input  logic [31:0] bus_rdata
);
  localparam int          CW        = $clog2(TMO);
  localparam logic [4:0]  DEV_LIMIT = 5'(MAX_DEV);
  localparam logic [44:0] CFG_LIMIT = 45'd1 << CFG_SPAN_BITS;
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} st_t;
  st_t st;

  logic        cfg_sel, abort_q, a_cfg, a_write, a_rmw, res_err;
  logic [1:0]  hi_bits;
  logic [4:0]  a_sh;
  logic [31:0] a_addr, a_wdata, a_bmask, res_data;
  logic [CW-1:0] cnt;

  logic [4:0]  dev, sh;
  logic [2:0]  func;
  logic [44:0] cfg_full;
  logic [31:0] bmask, lane_mask;
  logic        in_win, cfg_bad, sub_word, fail, abort_clr;

  assign dev       = req_addr[15:11];
  assign func      = req_addr[10:8];
  assign sh        = {req_addr[1:0], 3'b000};
  assign in_win    = req_addr[31:30] == 2'b10;
  assign sub_word  = !req_size[1];
  assign bmask     = (req_size == 2'd0) ? 32'h0000_00FF :
                     (req_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign cfg_full  = (45'd1 << ({1'b0, dev} + 6'd13)) | {34'd0, func, 8'd0}
                   | {37'd0, req_addr[7:2], 2'b00};
  assign cfg_bad   = (dev > DEV_LIMIT) || (cfg_full >= CFG_LIMIT);
  assign lane_mask = a_bmask << a_sh;
  assign fail      = bus_abort || (!bus_ack && cnt == CNT_LAST);
  assign abort_clr = reg_wr && reg_sel && reg_wdata[ABORT_BIT];

  assign req_ready = st == S_RESP;
  assign req_err   = res_err;
  assign req_rdata = res_data;
  assign bus_req   = st == S_BUS;
  assign bus_cfg   = a_cfg;
  assign bus_write = a_write;
  assign bus_addr  = a_addr;
  assign bus_wdata = a_wdata;
  assign reg_rdata = reg_sel ? (32'(abort_q) << ABORT_BIT)
                             : {28'd0, hi_bits, cfg_sel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel <= 1'b0;
      hi_bits <= 2'b00;
    end else if (reg_wr && !reg_sel) begin
      cfg_sel <= reg_wdata[1];
      hi_bits <= reg_wdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   abort_q <= 1'b0;
    else if (st == S_BUS && fail) abort_q <= 1'b1;
    else if (abort_clr)           abort_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      a_cfg    <= 1'b0;
      a_write  <= 1'b0;
      a_rmw    <= 1'b0;
      a_addr   <= '0;
      a_wdata  <= '0;
      a_bmask  <= '0;
      a_sh     <= '0;
      cnt      <= '0;
      res_err  <= 1'b0;
      res_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cnt <= '0;
          if (!in_win || (cfg_sel && cfg_bad)) begin
            st       <= S_RESP;
            res_err  <= 1'b1;
            res_data <= '1;
          end else begin
            st      <= S_BUS;
            a_cfg   <= cfg_sel;
            a_addr  <= cfg_sel ? cfg_full[31:0] : {hi_bits, req_addr[29:0]};
            a_sh    <= cfg_sel ? sh : 5'd0;
            a_bmask <= cfg_sel ? bmask : 32'hFFFF_FFFF;
            a_wdata <= cfg_sel ? (req_wdata << sh) : req_wdata;
            a_rmw   <= req_write && cfg_sel && sub_word;
            a_write <= req_write && !(cfg_sel && sub_word);
          end
        end
        S_BUS: begin
          if (fail) begin
            st       <= S_RESP;
            res_err  <= 1'b1;
            res_data <= '1;
          end else if (bus_ack) begin
            if (a_rmw) begin
              a_rmw   <= 1'b0;
              a_write <= 1'b1;
              a_wdata <= (bus_rdata & ~lane_mask) | (a_wdata & lane_mask);
              cnt     <= '0;
            end else begin
              st       <= S_RESP;
              res_err  <= 1'b0;
              res_data <= a_write ? 32'd0 : ((bus_rdata >> a_sh) & a_bmask);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R8
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_abort && cnt != CNT_LAST
      |=> bus_req && $stable(bus_addr) && $stable(bus_write)); // R8
  AST_CFG_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_cfg |-> $countones(bus_addr[31:13]) == 1
      && bus_addr[31:CFG_SPAN_BITS] == '0); // R3
  AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_abort |=> abort_q); // R5
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q && !abort_clr |=> abort_q); // R5
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_err |-> req_rdata == 32'hFFFF_FFFF); // R6
  AST_TMO_END: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && cnt == CNT_LAST |=> !bus_req && req_ready && abort_q); // R9
endmodule

// File: tb/cfg_bridge_test.sv
module cfg_bridge_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  rq;
    logic [3:0]  misc;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] brd;
    logic        err;
    logic [31:0] rd;
    logic [31:0] baddr;
    logic [31:0] bwd;
    logic [1:0]  nbus;
    logic        bcfg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 4'h4, 1'b0, 2'd2, 32'h8000_1234, 32'h0, 32'hCAFE_F00D, 1'b0, 32'hCAFE_F00D, 32'h4000_1234, 32'h0, 2'd1, 1'b0}, // R2
    '{4'd2, 4'hC, 1'b1, 2'd2, 32'hBFFF_FFFC, 32'h1234_5678, 32'h0, 1'b0, 32'h0, 32'hFFFF_FFFC, 32'h1234_5678, 2'd1, 1'b0}, // R2
    '{4'd3, 4'h2, 1'b0, 2'd2, 32'h8000_1110, 32'h0, 32'hAABB_CCDD, 1'b0, 32'hAABB_CCDD, 32'h0000_8110, 32'h0, 2'd1, 1'b1}, // R3
    '{4'd7, 4'h2, 1'b0, 2'd0, 32'h8000_0013, 32'h0, 32'hAABB_CCDD, 1'b0, 32'h0000_00AA, 32'h0000_2010, 32'h0, 2'd1, 1'b1}, // R7
    '{4'd7, 4'h2, 1'b0, 2'd1, 32'h8000_370A, 32'h0, 32'h1122_3344, 1'b0, 32'h0000_1122, 32'h0008_0708, 32'h0, 2'd1, 1'b1}, // R7
    '{4'd7, 4'h2, 1'b1, 2'd0, 32'h8000_0805, 32'h0000_00EE, 32'h1122_3344, 1'b0, 32'h0, 32'h0000_4004, 32'h1122_EE44, 2'd2, 1'b1}, // R7
    '{4'd7, 4'h2, 1'b1, 2'd1, 32'h8000_1802, 32'h0000_BEEF, 32'h1122_3344, 1'b0, 32'h0, 32'h0001_0000, 32'hBEEF_3344, 2'd2, 1'b1}, // R7
    '{4'd3, 4'h2, 1'b1, 2'd2, 32'h8000_223C, 32'hDEAD_BEEF, 32'h0, 1'b0, 32'h0, 32'h0002_023C, 32'hDEAD_BEEF, 2'd1, 1'b1}, // R3
    '{4'd4, 4'h2, 1'b0, 2'd2, 32'h8000_3800, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b0}, // R4
    '{4'd4, 4'h2, 1'b1, 2'd2, 32'h8000_9800, 32'h1, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b0}, // R4
    '{4'd1, 4'h0, 1'b0, 2'd2, 32'h4000_0000, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b0}, // R1
    '{4'd1, 4'h2, 1'b1, 2'd2, 32'hC000_0000, 32'h5, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b0}, // R1
    '{4'd2, 4'h0, 1'b0, 2'd2, 32'h9000_0000, 32'h0, 32'h5A5A_5A5A, 1'b0, 32'h5A5A_5A5A, 32'h1000_0000, 32'h0, 2'd1, 1'b0}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, req_err;
  logic [31:0] req_rdata;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_req, bus_cfg, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack, bus_abort;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;
  int bus_mode = 0, bus_lat = 0, wcnt;
  logic [31:0] bus_rd_val = '0;
  int n_bus, n_req_cyc;
  logic [31:0] last_addr, last_wdata;
  logic last_cfg, last_write;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_err(req_err), .req_rdata(req_rdata),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_cfg(bus_cfg), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_abort(bus_abort), .bus_rdata(bus_rdata)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; bus_abort = 1'b0; bus_rdata = '0; wcnt = 0;
      n_bus = 0; n_req_cyc = 0;
      last_addr = '0; last_wdata = '0; last_cfg = 1'b0; last_write = 1'b0;
    end else if (bus_ack || bus_abort) begin
      bus_ack = 1'b0; bus_abort = 1'b0; wcnt = 0;
    end else if (bus_req) begin
      n_req_cyc++;
      if (bus_mode != 2 && wcnt >= bus_lat) begin
        if (bus_mode == 1) bus_abort = 1'b1; else bus_ack = 1'b1;
        bus_rdata  = bus_rd_val;
        n_bus++;
        last_addr  = bus_addr;
        last_wdata = bus_wdata;
        last_cfg   = bus_cfg;
        last_write = bus_write;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_req(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                        output logic e, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_ready && cyc < 100);
    e = req_err; rd = req_rdata;
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    logic [31:0] rd, r;
    int cyc, nb0, nc0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "ready after reset", 32'(req_ready), 32'd0);
    chk("R8", "bus_req after reset", 32'(bus_req), 32'd0);
    rd_reg(1'b0, r); chk("R10", "control after reset", r, 32'h0);
    rd_reg(1'b1, r); chk("R10", "status after reset", r, 32'h0);

    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, r); chk("R10", "control readback", r, 32'h0000_000E);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rq);
      wr_reg(1'b0, {28'd0, VEC[i].misc});
      bus_mode = 0; bus_lat = i % 3; bus_rd_val = VEC[i].brd;
      nb0 = n_bus; nc0 = n_req_cyc;
      do_req(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd, e, rd, cyc);
      chk(rq, $sformatf("vec%0d err", i), 32'(e), 32'(VEC[i].err));
      chk(rq, $sformatf("vec%0d rdata", i), rd, VEC[i].rd);
      chk(rq, $sformatf("vec%0d bus cycles", i), 32'(n_bus - nb0), 32'(VEC[i].nbus));
      if (VEC[i].nbus == 2'd0)
        chk(rq, $sformatf("vec%0d bus idle", i), 32'(n_req_cyc - nc0), 32'd0);
      else begin
        chk(rq, $sformatf("vec%0d bus addr", i), last_addr, VEC[i].baddr);
        chk(rq, $sformatf("vec%0d bus cfg", i), 32'(last_cfg), 32'(VEC[i].bcfg));
        chk(rq, $sformatf("vec%0d bus write", i), 32'(last_write), 32'(VEC[i].wr));
        if (VEC[i].wr)
          chk(rq, $sformatf("vec%0d bus wdata", i), last_wdata, VEC[i].bwd);
      end
      rd_reg(1'b1, r); chk(rq, $sformatf("vec%0d abort flag clean", i), r, 32'h0);
    end

    // R8: completion latency with a slow bus
    wr_reg(1'b0, 32'h0);
    bus_mode = 0; bus_lat = 5; bus_rd_val = 32'h0BAD_CAFE;
    do_req(1'b0, 2'd2, 32'h8000_0040, 32'h0, e, rd, cyc);
    chk("R8", "latency lat=5", 32'(cyc), 32'd7);
    chk("R8", "slow read data", rd, 32'h0BAD_CAFE);

    // R6 / R5: aborted configuration read, sticky flag and write-one clear
    wr_reg(1'b0, 32'h2);
    bus_mode = 1; bus_lat = 1;
    do_req(1'b0, 2'd2, 32'h8000_0000, 32'h0, e, rd, cyc);
    chk("R6", "abort read err", 32'(e), 32'd1);
    chk("R6", "abort read ones", rd, 32'hFFFF_FFFF);
    rd_reg(1'b1, r); chk("R5", "flag set", r, 32'h0400_0000);
    wr_reg(1'b1, 32'hFBFF_FFFF);
    rd_reg(1'b1, r); chk("R5", "flag kept on zero write", r, 32'h0400_0000);
    wr_reg(1'b1, 32'h0400_0000);
    rd_reg(1'b1, r); chk("R5", "flag cleared", r, 32'h0);

    // R7: abort during read phase of a sub-word write stops the write
    nb0 = n_bus;
    do_req(1'b1, 2'd0, 32'h8000_0801, 32'h55, e, rd, cyc);
    chk("R7", "rmw abort err", 32'(e), 32'd1);
    chk("R7", "rmw abort single cycle", 32'(n_bus - nb0), 32'd1);
    chk("R7", "rmw abort was read", 32'(last_write), 32'd0);
    wr_reg(1'b1, 32'h0400_0000);

    // R5: memory write abort also latches the flag
    wr_reg(1'b0, 32'h0);
    do_req(1'b1, 2'd2, 32'h8000_0100, 32'h77, e, rd, cyc);
    chk("R6", "mem abort err", 32'(e), 32'd1);
    rd_reg(1'b1, r); chk("R5", "mem abort flag", r, 32'h0400_0000);
    wr_reg(1'b1, 32'h0400_0000);

    // R9: silent bus times out after 16 cycles
    bus_mode = 2;
    nc0 = n_req_cyc;
    do_req(1'b0, 2'd2, 32'h8000_0200, 32'h0, e, rd, cyc);
    chk("R9", "timeout bus cycles", 32'(n_req_cyc - nc0), 32'd16);
    chk("R9", "timeout err", 32'(e), 32'd1);
    chk("R9", "timeout data", rd, 32'hFFFF_FFFF);
    rd_reg(1'b1, r); chk("R9", "timeout flag", r, 32'h0400_0000);
    bus_mode = 0;
    wr_reg(1'b1, 32'h0400_0000);
    rd_reg(1'b1, r); chk("R5", "flag cleared after timeout", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule